// File: doc/BRIEF.md
# Programmable-Phase Pulse-Per-Second Generator

This block produces a one-pulse-per-second timing output from a fast clock that is phase-locked to a frequency reference. In the default build the clock is 60 MHz, which is a 10 MHz reference multiplied by six. A free-running cycle counter spans one second, which is `PERIOD` cycles (60,000,000 by default). The output pulse starts at a programmable cycle within that second, so it can be placed with one-clock resolution (about 16.67 ns). Its rising edge comes from the counter state and is then registered through a last flip-flop on the same clock. This keeps the output edge timing fixed relative to the clock.

The host can change the pulse position at any time by writing an offset. The block stages the new value and adopts it at the next counter rollover, so that each second carries exactly one pulse. The block never copies the external reference pulse onto its own output, because that reference may wander by more than 100 ns. Instead it synchronises the reference, finds its rising edge, and reports the signed distance in cycles from its own pulse to that edge. Firmware can then request controlled phase steps.

A three-state tracker watches the reference:
- **ACQUIRE** is the state after reset.
- **TRACK** means reference edges are arriving.
- **LOST** means no edge came within two seconds.

The transitions are:
- ACQUIRE→TRACK and TRACK→TRACK on a reference edge. Each of these transitions delivers a result.
- ACQUIRE→LOST and TRACK→LOST when the timeout expires.
- LOST→TRACK on a reference edge. This edge clears the flag but delivers no result.

Top module: `pps_phase_gen`

## Requirements
- R1: After the first pulse, `pps_out` rises exactly every `PERIOD` cycles while the offset is unchanged. With E0 taken as the first rising clock edge at which `rst_n` is sampled high, rises occur at edges E0 + offset + k·`PERIOD`.
- R2: After reset the active offset is 0 and all outputs are low, so the first rise of `pps_out` is at edge E0.
- R3: Each pulse holds `pps_out` high for exactly `HIGH_CYCLES` consecutive cycles (6,000,000 by default).
- R4: An offset write in the range 0 to `PERIOD`-1, made before the last cycle of a second, takes effect from the next second. The second in which the write occurs keeps its single pulse at the old position. The next second has one pulse at the new offset. No pulse is ever missing or doubled.
- R5: An offset write with `ofs_wdata` ≥ `PERIOD` leaves the pulse positions unchanged and sets `ofs_err` from the cycle after the write.
- R6: `ofs_err` stays high until reset.
- R7: The reference input passes through a two-flop synchroniser and a rising-edge detector. For a reference level first sampled high at edge T, `phase_valid` is high for one cycle after edge T+2. In that cycle `phase_err` carries (T − E0 − offset) mod `PERIOD`, wrapped as described in R8.
- R8: `phase_err` is a two's-complement value of width clog2(`PERIOD`)+1 (27 bits by default). Residues at or above `PERIOD`/2 map to residue − `PERIOD`, giving a range of −`PERIOD`/2 to `PERIOD`/2−1. For example, with `PERIOD`=40 a residue of 20 reads −20 and a residue of 19 reads +19.
- R9: When 2·`PERIOD` cycles pass with no detected reference edge, `ref_lost` rises. Counting starts from reset or from the last detected edge. With no edge after reset, `ref_lost` is high after edge E0+2·`PERIOD`−1 and low after the edge before it.
- R10: While `ref_lost` is high, `phase_valid` is suppressed. The first reference edge in that state clears `ref_lost` and produces no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock locked to the frequency reference (60 MHz default) |
| rst_n | input | 1 | Active-low synchronous reset |
| ofs_wr | input | 1 | Offset write strobe, one cycle |
| ofs_wdata | input | clog2(PERIOD) | Requested pulse position in cycles |
| ref_pps_in | input | 1 | Asynchronous external reference pulse |
| pps_out | output | 1 | Registered generated pulse |
| ofs_err | output | 1 | Sticky flag: an out-of-range offset was written |
| phase_err | output | clog2(PERIOD)+1 | Signed cycles from the generated pulse to the reference edge |
| phase_valid | output | 1 | One-cycle strobe marking a new `phase_err` |
| ref_lost | output | 1 | No reference edge for two seconds |

## Verification
The bench targets the following corner cases, each with the failure it would expose:
- **Offset moves in both directions.** A later, an earlier and a maximum offset are written mid-second. A design that applied the value at once would emit a doubled pulse or skip a second.
- **Out-of-range write.** A write equal to `PERIOD` is issued. Missing range logic would shift the pulse and leave `ofs_err` low.
- **Wrap boundaries.** The phase error is checked exactly at the −`PERIOD`/2 and `PERIOD`/2−1 limits, and also at zero. An off-by-one in the wrap or in the synchroniser latency would show up as a wrong signed value.
- **Timeout and recovery.** The timeout is measured to the exact cycle, both from reset and from the last edge. The recovering edge is checked to produce no result; a design that failed to suppress it would emit a spurious strobe.

// File: rtl/pps_gen_pkg.sv
package pps_gen_pkg;
    typedef enum logic [1:0] {
        REF_ACQUIRE = 2'd0,
        REF_TRACK   = 2'd1,
        REF_LOST    = 2'd2
    } ref_state_e;
endpackage

// File: rtl/pps_offset_ctl.sv
module pps_offset_ctl #(
    parameter int PERIOD = 60_000_000,
    parameter int CW     = $clog2(PERIOD)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [CW-1:0] wdata,
    input  logic          rollover,
    output logic [CW-1:0] act_ofs,
    output logic          err
);
    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

    logic [CW-1:0] pend_ofs;
    logic          in_range;

    assign in_range = (wdata <= LAST);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_ofs <= '0;
            act_ofs  <= '0;
            err      <= 1'b0;
        end else begin
            if (wr && in_range)  pend_ofs <= wdata;
            if (wr && !in_range) err      <= 1'b1;
            if (rollover)        act_ofs  <= pend_ofs;
        end
    end

    // R5: an out-of-range write leaves the staged value alone and flags it
    a_r5_ignore_bad_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && (wdata > LAST)) |=> ($stable(pend_ofs) && err));
    // R6: the error flag never clears outside reset
    a_r6_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);
    // R4: the active offset changes only on a rollover
    a_r4_apply_at_rollover: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(act_ofs) |-> $past(rollover));
endmodule

// File: rtl/pps_pulse_gen.sv
module pps_pulse_gen #(
    parameter int PERIOD      = 60_000_000,
    parameter int HIGH_CYCLES = 6_000_000,
    parameter int CW          = $clog2(PERIOD)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] act_ofs,
    output logic [CW-1:0] cnt,
    output logic          rollover,
    output logic          pps_out
);
    localparam int            HW   = $clog2(HIGH_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

    logic [HW-1:0] hi_left;
    logic          start;
    logic          pulse_dec;

    assign rollover  = (cnt == LAST);
    assign start     = (cnt == act_ofs);
    assign pulse_dec = start || (hi_left != '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            hi_left <= '0;
            pps_out <= 1'b0;
        end else begin
            cnt <= rollover ? '0 : cnt + 1'b1;
            if (start)                hi_left <= HW'(HIGH_CYCLES - 1);
            else if (hi_left != '0)   hi_left <= hi_left - 1'b1;
            pps_out <= pulse_dec;       // final retiming flop
        end
    end

    // R1: the second counter wraps to zero after its last cycle
    a_r1_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == LAST) |=> (cnt == '0));
    // R3: a rising output edge begins a countdown of the remaining high cycles
    a_r3_rise_loads: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pps_out) |-> $past(start));
endmodule

// File: rtl/pps_ref_sync.sv
module pps_ref_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_in,
    output logic ref_edge
);
    logic meta_q, sync_q, prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= ref_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign ref_edge = sync_q && !prev_q;

    // R7: an edge is reported for a single cycle only
    a_r7_edge_single: assert property (@(posedge clk) disable iff (!rst_n)
        ref_edge |=> !ref_edge);
endmodule

// File: rtl/pps_phase_meter.sv
module pps_phase_meter
    import pps_gen_pkg::*;
#(
    parameter int PERIOD = 60_000_000,
    parameter int CW     = $clog2(PERIOD),
    parameter int EW     = CW + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ref_edge,
    input  logic [CW-1:0]        cnt,
    input  logic [CW-1:0]        act_ofs,
    output logic signed [EW-1:0] phase_err,
    output logic                 phase_valid,
    output logic                 ref_lost
);
    localparam int            XW   = $clog2(3 * PERIOD) + 1;
    localparam int            LAT  = 2;  // synchroniser stages ahead of the edge
    localparam int            TW   = $clog2(2 * PERIOD);
    localparam logic [TW-1:0] TLIM = TW'(2 * PERIOD - 1);
    localparam logic [XW-1:0] HALF = XW'(PERIOD / 2);
    localparam logic [XW-1:0] P1   = XW'(PERIOD);
    localparam logic [XW-1:0] P2   = XW'(2 * PERIOD);

    ref_state_e state, state_nx;
    logic [TW-1:0]        tmo;
    logic                 timeout;
    logic [XW-1:0]        x, u;
    logic signed [XW:0]   wrapped;

    assign timeout = (tmo == TLIM) && !ref_edge;

    // residue of (cnt - LAT - act_ofs) modulo PERIOD, then signed wrap
    always_comb begin
        x = XW'(cnt) + XW'(2 * PERIOD - LAT) - XW'(act_ofs);
        if (x >= P2)      u = x - P2;
        else if (x >= P1) u = x - P1;
        else              u = x;
        if (u >= HALF) wrapped = $signed({1'b0, u}) - $signed({1'b0, P1});
        else           wrapped = $signed({1'b0, u});
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            REF_ACQUIRE: if (ref_edge) state_nx = REF_TRACK;
                         else if (timeout) state_nx = REF_LOST;
            REF_TRACK:   if (timeout) state_nx = REF_LOST;
            REF_LOST:    if (ref_edge) state_nx = REF_TRACK;
            default:     state_nx = REF_ACQUIRE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= REF_ACQUIRE;
            tmo   <= '0;
        end else begin
            state <= state_nx;
            if (ref_edge)         tmo <= '0;
            else if (tmo != TLIM) tmo <= tmo + 1'b1;
        end
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_valid <= 1'b0;
            phase_err   <= '0;
        end else begin
            phase_valid <= ref_edge && (state != REF_LOST);
            if (ref_edge && (state != REF_LOST)) phase_err <= EW'(wrapped);
        end
    end

    assign ref_lost = (state == REF_LOST);

    // R10: no result is delivered while the reference is flagged lost
    a_r10_no_valid_when_lost: assert property (@(posedge clk) disable iff (!rst_n)
        phase_valid |-> !ref_lost);
    // R8: every delivered result lies inside the wrapped window
    a_r8_range: assert property (@(posedge clk) disable iff (!rst_n)
        phase_valid |-> ((phase_err >= -$signed(EW'(PERIOD / 2))) &&
                         (phase_err <  $signed(EW'(PERIOD - PERIOD / 2)))));
    // R9: the lost state is entered only after the full timeout
    a_r9_lost_after_timeout: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ref_lost) |-> ($past(tmo) == TLIM));
endmodule

// File: rtl/pps_phase_gen.sv
module pps_phase_gen #(
    parameter int PERIOD      = 60_000_000,
    parameter int HIGH_CYCLES = 6_000_000,
    parameter int CW          = $clog2(PERIOD),
    parameter int EW          = CW + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ofs_wr,
    input  logic [CW-1:0]        ofs_wdata,
    input  logic                 ref_pps_in,
    output logic                 pps_out,
    output logic                 ofs_err,
    output logic signed [EW-1:0] phase_err,
    output logic                 phase_valid,
    output logic                 ref_lost
);
    logic [CW-1:0] act_ofs;
    logic [CW-1:0] cnt;
    logic          rollover;
    logic          ref_edge;

    pps_offset_ctl #(.PERIOD(PERIOD), .CW(CW)) u_ofs (
        .clk(clk), .rst_n(rst_n), .wr(ofs_wr), .wdata(ofs_wdata),
        .rollover(rollover), .act_ofs(act_ofs), .err(ofs_err)
    );

    pps_pulse_gen #(.PERIOD(PERIOD), .HIGH_CYCLES(HIGH_CYCLES), .CW(CW)) u_gen (
        .clk(clk), .rst_n(rst_n), .act_ofs(act_ofs), .cnt(cnt),
        .rollover(rollover), .pps_out(pps_out)
    );

    pps_ref_sync u_sync (
        .clk(clk), .rst_n(rst_n), .ref_in(ref_pps_in), .ref_edge(ref_edge)
    );

    pps_phase_meter #(.PERIOD(PERIOD), .CW(CW), .EW(EW)) u_meter (
        .clk(clk), .rst_n(rst_n), .ref_edge(ref_edge), .cnt(cnt),
        .act_ofs(act_ofs), .phase_err(phase_err), .phase_valid(phase_valid),
        .ref_lost(ref_lost)
    );
endmodule

// File: tb/tb_pps_phase_gen.sv
module tb_pps_phase_gen;
    localparam int P  = 40;
    localparam int HI = 4;
    localparam int CW = $clog2(P);
    localparam int EW = CW + 1;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 ofs_wr = 1'b0;
    logic [CW-1:0]        ofs_wdata = '0;
    logic                 ref_pps_in = 1'b0;
    logic                 pps_out, ofs_err, phase_valid, ref_lost;
    logic signed [EW-1:0] phase_err;

    int checks = 0;
    int errors = 0;
    int ecnt   = -1;
    bit done   = 1'b0;

    int    rise_q[$];
    string rise_tag[$];
    int    ph_q[$];
    string ph_tag[$];

    always #4 clk = ~clk;

    pps_phase_gen #(.PERIOD(P), .HIGH_CYCLES(HI)) dut (
        .clk(clk), .rst_n(rst_n), .ofs_wr(ofs_wr), .ofs_wdata(ofs_wdata),
        .ref_pps_in(ref_pps_in), .pps_out(pps_out), .ofs_err(ofs_err),
        .phase_err(phase_err), .phase_valid(phase_valid), .ref_lost(ref_lost)
    );

    always @(posedge clk) ecnt <= rst_n ? ecnt + 1 : -1;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s at edge %0d: actual %0d expected %0d", tag, ecnt, act, exp);
        end
    endtask

    task automatic push_rise(input int e, input string tag);
        rise_q.push_back(e);
        rise_tag.push_back(tag);
    endtask

    function automatic int exp_phase(input int t, input int ofs);
        int m;
        m = ((t - ofs) % P + P) % P;
        return (m >= P / 2) ? m - P : m;
    endfunction

    task automatic wait_ecnt(input int n);
        while (ecnt != n) @(negedge clk);
    endtask

    task automatic write_ofs(input int at, input int val);
        wait_ecnt(at);
        ofs_wr    = 1'b1;
        ofs_wdata = CW'(val);
        @(negedge clk);
        ofs_wr    = 1'b0;
    endtask

    task automatic ref_pulse(input int t, input int ofs, input bit expect_res, input string tag);
        wait_ecnt(t - 1);
        ref_pps_in = 1'b1;
        if (expect_res) begin
            ph_q.push_back(exp_phase(t, ofs));
            ph_tag.push_back(tag);
        end
        repeat (3) @(negedge clk);
        ref_pps_in = 1'b0;
    endtask

    // monitor: pops expected pulse edges and results as the design produces them
    bit prev_pps = 1'b0;
    int rise_at  = 0;
    always @(negedge clk) begin
        if (rst_n && ecnt >= 0 && !done) begin
            if (pps_out && !prev_pps) begin
                if (rise_q.size() == 0) chk(1'b0, "R4 unexpected pulse", ecnt, -1);
                else chk(ecnt == rise_q[0], rise_tag[0], ecnt, rise_q[0]);
                if (rise_q.size() != 0) begin
                    void'(rise_q.pop_front());
                    void'(rise_tag.pop_front());
                end
                rise_at = ecnt;
            end
            if (!pps_out && prev_pps)
                chk((ecnt - rise_at) == HI, "R3 pulse width", ecnt - rise_at, HI);
            if (phase_valid) begin
                if (ph_q.size() == 0) chk(1'b0, "R10 unexpected result", int'(phase_err), 0);
                else begin
                    chk(int'(phase_err) == ph_q[0], ph_tag[0], int'(phase_err), ph_q[0]);
                    void'(ph_q.pop_front());
                    void'(ph_tag.pop_front());
                end
            end
            prev_pps = pps_out;
        end
    end

    initial begin
        #(200000 * 8);
        errors++;
        $display("FAIL watchdog expired at edge %0d", ecnt);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // driver: expected pulse edges
        push_rise(0,   "R2 first pulse");
        push_rise(40,  "R1 period");
        push_rise(80,  "R1 period");
        push_rise(133, "R4 later offset");
        push_rise(173, "R5 ignored write");
        push_rise(213, "R5 ignored write");
        push_rise(279, "R4 max offset");
        push_rise(300, "R4 earlier offset");
        for (int k = 340; k <= 580; k += 40) push_rise(k, "R1 period");

        repeat (4) @(negedge clk);
        chk(pps_out == 1'b0,     "R2 reset pps_out",     pps_out, 0);
        chk(phase_valid == 1'b0, "R2 reset phase_valid", phase_valid, 0);
        chk(ref_lost == 1'b0,    "R2 reset ref_lost",    ref_lost, 0);
        chk(ofs_err == 1'b0,     "R2 reset ofs_err",     ofs_err, 0);
        rst_n = 1'b1;

        wait_ecnt(78);
        chk(ref_lost == 1'b0, "R9 lost too early", ref_lost, 0);
        wait_ecnt(79);
        chk(ref_lost == 1'b1, "R9 lost after timeout", ref_lost, 1);

        write_ofs(90, 13);
        wait_ecnt(150);
        chk(ofs_err == 1'b0, "R5 err before bad write", ofs_err, 0);
        write_ofs(150, P);
        wait_ecnt(152);
        chk(ofs_err == 1'b1, "R5 err after bad write", ofs_err, 1);
        write_ofs(225, P - 1);
        write_ofs(260, 20);
        wait_ecnt(300);
        chk(ofs_err == 1'b1, "R6 err sticky", ofs_err, 1);

        wait_ecnt(329);
        chk(ref_lost == 1'b1, "R10 still lost", ref_lost, 1);
        ref_pulse(330, 20, 1'b0, "R10");
        chk(ref_lost == 1'b0, "R10 recovered", ref_lost, 0);
        ref_pulse(345, 20, 1'b1, "R7 phase +5");
        ref_pulse(375, 20, 1'b1, "R8 phase -5");
        ref_pulse(400, 20, 1'b1, "R8 phase lower bound");
        ref_pulse(439, 20, 1'b1, "R8 phase upper bound");
        ref_pulse(460, 20, 1'b1, "R7 phase zero");

        wait_ecnt(541);
        chk(ref_lost == 1'b0, "R9 lost too early after edge", ref_lost, 0);
        wait_ecnt(542);
        chk(ref_lost == 1'b1, "R9 lost after edge timeout", ref_lost, 1);

        wait_ecnt(600);
        done = 1'b1;
        chk(rise_q.size() == 0, "R4 missing pulse", rise_q.size(), 0);
        chk(ph_q.size() == 0,   "R7 missing result", ph_q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule